// File: doc/BRIEF.md
# Length-Prefixed Frame Link Buffer Engine

This block is the byte-level core of a data link controller. A host processor reaches it through an 8-bit register bus with a 5-bit address. A DMA engine moves payload bytes: it drains a receive frame buffer and fills a transmit frame buffer, paced by two request lines. Whole frames travel over a pair of byte streams. Each frame on a stream starts with a 16-bit length, least significant byte first, and the payload bytes follow.

On the receive side, a frame is taken from the inbound stream only while reception is enabled and the receive buffer is empty. Taking a frame loads fixed status codes and can raise the receive DMA request. The host then empties the buffer through the data register, the DMA engine, or both. On the transmit side, DMA writes collect bytes into the transmit buffer. A rising terminal-count pulse, seen while the transmit acknowledge is low, closes the frame. The engine then sends the length prefix and the stored bytes on the outbound stream under valid/ready flow control.

Top module: `lnk_frame_engine`

## Requirements
- R1: After reset, receive status 0 (address 0x08) reads 0x00, receive status 1 (0x09) reads 0x08, and transmit status (0x0C) reads 0x60. Both DMA requests, `txOutValid` and `rxInReady` are low.
- R2: A read from any address other than 0x08, 0x09, 0x0C, 0x0F and 0x15 returns 0xFF. The port register at 0x15 reads back the last byte written to it.
- R3: A write to receive control (0x0A) with bit 1 set empties the receive buffer and sets receive status 0 to 0x06. A new frame can then be taken at once if bit 7 of the same write is set.
- R4: The inbound stream is ready only while receive control bit 7 is set and the receive buffer is empty. A frame arriving while the buffer still holds bytes waits on the stream.
- R5: When a frame is taken, receive status 0 becomes 0x01, or 0x41 if the frame holds one byte. Receive status 1 becomes 0xC8. The receive DMA request is set to (request mask bit 6 clear AND receive interrupt enable (0x0B) bit 7 set).
- R6: Each pop, by a read of 0x0F or a DMA read, returns the next byte in arrival order. Receive status 0 gains 0x40 when exactly one byte remains. After the last byte it becomes 0x06 and the buffer counts as empty.
- R7: A DMA read that takes the last byte drops the receive DMA request. A register pop of the last byte leaves the request unchanged.
- R8: Each DMA write sets transmit status to 0x6B and advances the write offset. The offset saturates at DEPTH-1, so a frame never exceeds DEPTH-1 bytes.
- R9: A rising `termCount` with `txAckN` low sets transmit status to 0x6F and zeros the offset. If the offset was nonzero, the frame is then sent as length low byte, length high byte, then payload. With `txAckN` high the pulse has no effect.
- R10: While `txOutValid` is high and `txOutReady` is low, `txOutValid` and `txOutData` hold.
- R11: Only a write to the request mask (0x17) updates the transmit DMA request, to (new mask bit 7 clear AND transmit control (0x0D) bit 7 AND transmit interrupt enable (0x0E) bit 7). A transmit control write with bit 3 set zeros the offset and ORs transmit status with 0x05.
- R12: While a frame is being sent, DMA writes and terminal-count pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe (pops at 0x0F) |
| regRdData | output | 8 | Register read data, combinational |
| dmaRxReq | output | 1 | Receive DMA request |
| dmaRxRd | input | 1 | DMA read strobe, pops one byte |
| dmaRxData | output | 8 | Byte at the receive head |
| dmaTxReq | output | 1 | Transmit DMA request |
| dmaTxWr | input | 1 | DMA write strobe |
| dmaTxData | input | 8 | DMA write byte |
| termCount | input | 1 | Terminal count, rising edge closes a frame |
| txAckN | input | 1 | Transmit acknowledge, active low |
| rxInValid | input | 1 | Inbound stream byte valid |
| rxInData | input | 8 | Inbound stream byte |
| rxInReady | output | 1 | Inbound stream ready |
| txOutValid | output | 1 | Outbound stream byte valid |
| txOutData | output | 8 | Outbound stream byte |
| txOutReady | input | 1 | Outbound stream ready |

## Verification
The bench builds the engine with DEPTH set to 16. This makes the offset cap of 15 reachable with a short burst of writes. It also lets every frame length from 1 to 15 be swept, with each payload looped from the outbound stream into the inbound stream. Expected status codes, popped bytes and request levels are computed from the frame length and the pop index. Register pops and DMA pops alternate, so the last byte falls to each path for half of the lengths.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  localparam logic [4:0] A_RXST0  = 5'h08;
  localparam logic [4:0] A_RXST1  = 5'h09;
  localparam logic [4:0] A_RXCTRL = 5'h0A;
  localparam logic [4:0] A_RXIE   = 5'h0B;
  localparam logic [4:0] A_TXST   = 5'h0C;
  localparam logic [4:0] A_TXCTRL = 5'h0D;
  localparam logic [4:0] A_TXIE   = 5'h0E;
  localparam logic [4:0] A_DATA   = 5'h0F;
  localparam logic [4:0] A_PORT   = 5'h15;
  localparam logic [4:0] A_MASK   = 5'h17;

  localparam logic [7:0] ST0_IDLE  = 8'h06;
  localparam logic [7:0] ST0_READY = 8'h01;
  localparam logic [7:0] ST0_EOF   = 8'h40;
  localparam logic [7:0] ST1_FRAME = 8'hC8;
  localparam logic [7:0] TX_FILL   = 8'h6B;
  localparam logic [7:0] TX_DONE   = 8'h6F;
  localparam logic [7:0] TX_RSTOR  = 8'h05;

  typedef struct packed {
    logic rxPop;
    logic rxClear;
    logic txPush;
    logic txClear;
    logic txDone;
  } lnkStrobeT;

  typedef struct packed {
    logic rxCommit;
    logic rxCommitOne;
    logic popLast;
    logic popNextLast;
    logic txBusy;
  } lnkInfoT;
endpackage

// File: rtl/lnk_dpath.sv
module lnk_dpath
  import lnk_pkg::*;
#(
  parameter int DEPTH = 3840
) (
  input  logic      clk,
  input  logic      rstN,
  input  lnkStrobeT strobe,
  input  logic      rxEnable,
  input  logic [7:0] dmaTxData,
  output lnkInfoT   info,
  output logic [7:0] rxHead,
  input  logic      rxInValid,
  input  logic [7:0] rxInData,
  output logic      rxInReady,
  output logic      txOutValid,
  output logic [7:0] txOutData,
  input  logic      txOutReady
);
  localparam int LW = 16;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [LW-1:0] CAP_L   = LW'(DEPTH - 1);
  localparam logic [LW-1:0] ONE_L   = LW'(1);

  typedef enum logic [1:0] {IN_WAIT, IN_LENHI, IN_BODY} inStateT;
  typedef enum logic [1:0] {OUT_IDLE, OUT_LO, OUT_HI, OUT_BODY} outStateT;

  logic [7:0] rxMem [DEPTH];
  logic [7:0] txMem [DEPTH];

  inStateT     inState;
  logic [7:0]  lenLo;
  logic [LW-1:0] frameLen, wrCnt, rxLen, rxOff, rxOffNext;
  logic        inFire, rxCommit, rxMemWe;

  outStateT    outState;
  logic [LW-1:0] txOff, txOffInc, sendLen, rdCnt;
  logic        outFire;

  // receive side
  assign rxInReady = (inState == IN_WAIT) ? (rxEnable && rxLen == '0) : 1'b1;
  assign inFire    = rxInValid && rxInReady;
  assign rxCommit  = (inState == IN_BODY) && inFire && ((wrCnt + ONE_L) == frameLen);
  assign rxMemWe   = (inState == IN_BODY) && inFire && (wrCnt < DEPTH_L);
  assign rxOffNext = rxOff + ONE_L;
  assign rxHead    = rxMem[rxOff[AW-1:0]];

  assign info.rxCommit    = rxCommit;
  assign info.rxCommitOne = (frameLen == ONE_L);
  assign info.popLast     = (rxOffNext >= rxLen);
  assign info.popNextLast = ((rxOffNext + ONE_L) == rxLen);
  assign info.txBusy      = (outState != OUT_IDLE);

  always_ff @(posedge clk) begin
    if (rxMemWe) rxMem[wrCnt[AW-1:0]] <= rxInData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inState  <= IN_WAIT;
      lenLo    <= '0;
      frameLen <= '0;
      wrCnt    <= '0;
      rxLen    <= '0;
      rxOff    <= '0;
    end else begin
      if (inFire) begin
        unique case (inState)
          IN_WAIT: begin
            lenLo   <= rxInData;
            inState <= IN_LENHI;
          end
          IN_LENHI: begin
            frameLen <= {rxInData, lenLo};
            wrCnt    <= '0;
            inState  <= ({rxInData, lenLo} == '0) ? IN_WAIT : IN_BODY;
          end
          default: begin
            wrCnt <= wrCnt + ONE_L;
            if (rxCommit) inState <= IN_WAIT;
          end
        endcase
      end
      if (strobe.rxPop) begin
        if (info.popLast) begin
          rxLen <= '0;
          rxOff <= '0;
        end else begin
          rxOff <= rxOffNext;
        end
      end
      if (rxCommit) begin
        rxLen <= (frameLen > DEPTH_L) ? DEPTH_L : frameLen;
        rxOff <= '0;
      end
      if (strobe.rxClear) begin
        rxLen   <= '0;
        rxOff   <= '0;
        inState <= IN_WAIT;
      end
    end
  end

  // transmit side
  assign txOffInc   = txOff + ONE_L;
  assign txOutValid = (outState != OUT_IDLE);
  assign outFire    = txOutValid && txOutReady;

  always_comb begin
    unique case (outState)
      OUT_LO:   txOutData = sendLen[7:0];
      OUT_HI:   txOutData = sendLen[LW-1:8];
      OUT_BODY: txOutData = txMem[rdCnt[AW-1:0]];
      default:  txOutData = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.txPush) txMem[txOff[AW-1:0]] <= dmaTxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOff    <= '0;
      sendLen  <= '0;
      rdCnt    <= '0;
      outState <= OUT_IDLE;
    end else begin
      if (strobe.txPush) txOff <= (txOffInc > CAP_L) ? CAP_L : txOffInc;
      if (strobe.txClear) txOff <= '0;
      if (strobe.txDone && txOff != '0) begin
        sendLen  <= txOff;
        rdCnt    <= '0;
        outState <= OUT_LO;
      end else if (outFire) begin
        unique case (outState)
          OUT_LO: outState <= OUT_HI;
          OUT_HI: outState <= OUT_BODY;
          default: begin
            rdCnt <= rdCnt + ONE_L;
            if ((rdCnt + ONE_L) == sendLen) outState <= OUT_IDLE;
          end
        endcase
      end
    end
  end

  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txOutValid && !txOutReady) |=> (txOutValid && $stable(txOutData)));

  a_r12_offset_zero_busy: assert property (@(posedge clk) disable iff (!rstN)
    (outState != OUT_IDLE) |-> (txOff == '0));

  a_r4_ready_needs_empty: assert property (@(posedge clk) disable iff (!rstN)
    (inState == IN_WAIT && rxInReady) |-> (rxLen == '0 && rxEnable));
endmodule

// File: rtl/lnk_ctrl.sv
module lnk_ctrl
  import lnk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  input  logic       dmaRxRd,
  input  logic       dmaTxWr,
  input  logic       termCount,
  input  logic       txAckN,
  input  logic [7:0] rxHead,
  input  lnkInfoT    info,
  output lnkStrobeT  strobe,
  output logic       rxEnable,
  output logic       dmaRxReq,
  output logic       dmaTxReq
);
  logic [7:0] rxSt0, rxSt1, txSt, portReg, st0Next, txStNext;
  logic       rxEnBit, rxIeBit, txEnBit, txIeBit, maskRx, maskTx;
  logic       tcPrev, rxReqQ, txReqQ;
  logic       tcRise, doneC, pushC, huntC, txRstC, popC, maskWr;

  assign tcRise = termCount && !tcPrev;
  assign doneC  = tcRise && !txAckN && !info.txBusy;
  assign pushC  = dmaTxWr && !info.txBusy && !doneC;
  assign huntC  = regWrEn && regAddr == A_RXCTRL && regWrData[1];
  assign txRstC = regWrEn && regAddr == A_TXCTRL && regWrData[3];
  assign popC   = (regRdEn && regAddr == A_DATA) || dmaRxRd;
  assign maskWr = regWrEn && regAddr == A_MASK;

  assign strobe.rxPop   = popC;
  assign strobe.rxClear = huntC;
  assign strobe.txPush  = pushC;
  assign strobe.txClear = txRstC || doneC;
  assign strobe.txDone  = doneC;

  assign rxEnable = rxEnBit;
  assign dmaRxReq = rxReqQ;
  assign dmaTxReq = txReqQ;

  always_comb begin
    st0Next = rxSt0;
    if (popC) begin
      if (info.popLast) st0Next = ST0_IDLE;
      else if (info.popNextLast) st0Next = rxSt0 | ST0_EOF;
    end
    if (info.rxCommit) st0Next = info.rxCommitOne ? (ST0_READY | ST0_EOF) : ST0_READY;
    if (huntC) st0Next = ST0_IDLE;
  end

  always_comb begin
    txStNext = txSt;
    if (pushC) txStNext = TX_FILL;
    if (doneC) txStNext = TX_DONE;
    if (strobe.txClear) txStNext = txStNext | TX_RSTOR;
  end

  always_comb begin
    unique case (regAddr)
      A_RXST0: regRdData = rxSt0;
      A_RXST1: regRdData = rxSt1;
      A_TXST:  regRdData = txSt;
      A_DATA:  regRdData = rxHead;
      A_PORT:  regRdData = portReg;
      default: regRdData = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSt0   <= 8'h00;
      rxSt1   <= 8'h08;
      txSt    <= 8'h60;
      portReg <= 8'h00;
      rxEnBit <= 1'b0;
      rxIeBit <= 1'b0;
      txEnBit <= 1'b0;
      txIeBit <= 1'b0;
      maskRx  <= 1'b0;
      maskTx  <= 1'b0;
      tcPrev  <= 1'b0;
      rxReqQ  <= 1'b0;
      txReqQ  <= 1'b0;
    end else begin
      tcPrev <= termCount;
      rxSt0  <= st0Next;
      txSt   <= txStNext;
      if (info.rxCommit) rxSt1 <= ST1_FRAME;
      if (dmaRxRd && info.popLast) rxReqQ <= 1'b0;
      if (info.rxCommit) rxReqQ <= !maskRx && rxIeBit;
      if (regWrEn) begin
        unique case (regAddr)
          A_RXCTRL: rxEnBit <= regWrData[7];
          A_RXIE:   rxIeBit <= regWrData[7];
          A_TXCTRL: txEnBit <= regWrData[7];
          A_TXIE:   txIeBit <= regWrData[7];
          A_PORT:   portReg <= regWrData;
          A_MASK: begin
            maskRx <= regWrData[6];
            maskTx <= regWrData[7];
            txReqQ <= !regWrData[7] && txEnBit && txIeBit;
          end
          default: ;
        endcase
      end
    end
  end

  a_r5_rxreq_rises_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaRxReq) |-> $past(info.rxCommit));

  a_r7_rxreq_falls_on_dma: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaRxReq) |-> ($past(dmaRxRd) || $past(info.rxCommit)));

  a_r11_txreq_only_mask: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dmaTxReq) |-> $past(maskWr));

  a_r12_status_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (info.txBusy && !(regWrEn && regAddr == A_TXCTRL)) |=> $stable(txSt));
endmodule

// File: rtl/lnk_frame_engine.sv
module lnk_frame_engine
  import lnk_pkg::*;
#(
  parameter int DEPTH = 3840
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  output logic       dmaRxReq,
  input  logic       dmaRxRd,
  output logic [7:0] dmaRxData,
  output logic       dmaTxReq,
  input  logic       dmaTxWr,
  input  logic [7:0] dmaTxData,
  input  logic       termCount,
  input  logic       txAckN,
  input  logic       rxInValid,
  input  logic [7:0] rxInData,
  output logic       rxInReady,
  output logic       txOutValid,
  output logic [7:0] txOutData,
  input  logic       txOutReady
);
  lnkStrobeT strobe;
  lnkInfoT   info;
  logic [7:0] rxHead;
  logic       rxEnable;

  assign dmaRxData = rxHead;

  lnk_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .dmaRxRd(dmaRxRd), .dmaTxWr(dmaTxWr),
    .termCount(termCount), .txAckN(txAckN),
    .rxHead(rxHead), .info(info), .strobe(strobe),
    .rxEnable(rxEnable), .dmaRxReq(dmaRxReq), .dmaTxReq(dmaTxReq)
  );

  lnk_dpath #(.DEPTH(DEPTH)) uDpath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .rxEnable(rxEnable), .dmaTxData(dmaTxData),
    .info(info), .rxHead(rxHead),
    .rxInValid(rxInValid), .rxInData(rxInData), .rxInReady(rxInReady),
    .txOutValid(txOutValid), .txOutData(txOutData), .txOutReady(txOutReady)
  );
endmodule

// File: tb/tb_lnk_frame_engine.sv
`timescale 1ns/1ps
module tb_lnk_frame_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData, dmaRxData, txOutData;
  logic dmaRxReq, dmaTxReq, rxInReady, txOutValid;
  logic dmaRxRd = 1'b0, dmaTxWr = 1'b0, termCount = 1'b0, txAckN = 1'b0;
  logic [7:0] dmaTxData = '0;
  logic rxInValid, txOutReady;
  logic [7:0] rxInData;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign rxInValid  = txOutValid;
  assign rxInData   = txOutData;
  assign txOutReady = rxInReady;

  lnk_frame_engine #(.DEPTH(16)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .dmaRxReq(dmaRxReq), .dmaRxRd(dmaRxRd), .dmaRxData(dmaRxData),
    .dmaTxReq(dmaTxReq), .dmaTxWr(dmaTxWr), .dmaTxData(dmaTxData),
    .termCount(termCount), .txAckN(txAckN), .rxInValid(rxInValid),
    .rxInData(rxInData), .rxInReady(rxInReady), .txOutValid(txOutValid),
    .txOutData(txOutData), .txOutReady(txOutReady));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic dmaRd(output logic [7:0] d);
    @(negedge clk); dmaRxRd = 1'b1; #1 d = dmaRxData;
    @(negedge clk); dmaRxRd = 1'b0;
  endtask

  task automatic dmaWr(input logic [7:0] d);
    @(negedge clk); dmaTxData = d; dmaTxWr = 1'b1;
    @(negedge clk); dmaTxWr = 1'b0;
  endtask

  task automatic tcPulse();
    @(negedge clk); termCount = 1'b1;
    @(negedge clk); termCount = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int n, input int k);
    return 8'((n * 16 + k * 3 + 5) & 8'hFF);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    regRd(5'h08, d); chk("R1 st0", d, 8'h00);
    regRd(5'h09, d); chk("R1 st1", d, 8'h08);
    regRd(5'h0C, d); chk("R1 txst", d, 8'h60);
    chk("R1 rxreq", dmaRxReq, 0);
    chk("R1 txreq", dmaTxReq, 0);
    chk("R1 outvalid", txOutValid, 0);
    chk("R1 inready", rxInReady, 0);
    // R2 decode
    regRd(5'h00, d); chk("R2 unimpl 00", d, 8'hFF);
    regRd(5'h1F, d); chk("R2 unimpl 1F", d, 8'hFF);
    regRd(5'h0A, d); chk("R2 writeonly 0A", d, 8'hFF);
    regWr(5'h15, 8'h5A); regRd(5'h15, d); chk("R2 port", d, 8'h5A);
    // R11 transmit request
    regWr(5'h0E, 8'h80); regWr(5'h0D, 8'h80);
    chk("R11 no change without mask write", dmaTxReq, 0);
    regWr(5'h17, 8'h00); chk("R11 req set", dmaTxReq, 1);
    regWr(5'h17, 8'h80); chk("R11 req clear", dmaTxReq, 0);
    regWr(5'h17, 8'h00);
    // enable receive
    regWr(5'h0B, 8'h80); regWr(5'h0A, 8'h80);
    chk("R4 ready when empty", rxInReady, 1);
    // sweep all lengths, R5 R6 R7 R8 R9
    for (int n = 1; n <= 15; n++) begin
      for (int k = 0; k < n; k++) dmaWr(pat(n, k));
      regRd(5'h0C, d); chk("R8 txst fill", d, 8'h6B);
      tcPulse();
      regRd(5'h0C, d); chk("R9 txst done", d, 8'h6F);
      idle(n + 6);
      regRd(5'h08, d); chk("R5 st0 commit", d, (n == 1) ? 8'h41 : 8'h01);
      regRd(5'h09, d); chk("R5 st1 commit", d, 8'hC8);
      chk("R5 rxreq", dmaRxReq, 1);
      for (int k = 0; k < n; k++) begin
        if (k & 1) dmaRd(d); else regRd(5'h0F, d);
        chk("R6 data", d, pat(n, k));
        regRd(5'h08, d);
        chk("R6 st0 pop", d, (n - k - 1 == 0) ? 8'h06 : ((n - k - 1 == 1) ? 8'h41 : 8'h01));
      end
      chk("R7 rxreq after last", dmaRxReq, (n % 2 == 1) ? 1 : 0);
    end
    // R5 mask bit 6 blocks request
    regWr(5'h17, 8'h40);
    dmaWr(8'h77); tcPulse(); idle(8);
    chk("R5 masked rxreq", dmaRxReq, 0);
    regRd(5'h0F, d); chk("R5 masked data", d, 8'h77);
    regWr(5'h17, 8'h00);
    // R8 saturation
    for (int i = 0; i < 18; i++) dmaWr(8'(8'h20 + i));
    tcPulse(); idle(24);
    regRd(5'h08, d); chk("R8 st0 sat", d, 8'h01);
    for (int k = 0; k < 15; k++) begin
      regRd(5'h0F, d); chk("R8 sat data", d, 8'(8'h20 + k));
    end
    regRd(5'h08, d); chk("R8 frame 15 bytes", d, 8'h06);
    // R4 full buffer holds next frame
    dmaWr(8'h11); tcPulse(); idle(8);
    dmaWr(8'h22); dmaWr(8'h33); tcPulse(); idle(10);
    chk("R4 held valid", txOutValid, 1);
    chk("R4 inready low", rxInReady, 0);
    regRd(5'h08, d); chk("R4 st0 unchanged", d, 8'h41);
    regRd(5'h0F, d); chk("R4 first frame", d, 8'h11);
    idle(8);
    regRd(5'h08, d); chk("R4 second taken", d, 8'h01);
    regRd(5'h0F, d); chk("R4 b0", d, 8'h22);
    regRd(5'h0F, d); chk("R4 b1", d, 8'h33);
    // R3 hunt
    dmaWr(8'h44); dmaWr(8'h45); tcPulse(); idle(8);
    regRd(5'h08, d); chk("R3 pre", d, 8'h01);
    regWr(5'h0A, 8'h82);
    regRd(5'h08, d); chk("R3 st0 idle", d, 8'h06);
    chk("R3 ready again", rxInReady, 1);
    // R10 R12 stall
    regWr(5'h0A, 8'h00);
    dmaWr(8'h41); dmaWr(8'h42); dmaWr(8'h43); tcPulse(); idle(2);
    chk("R10 valid", txOutValid, 1);
    chk("R10 length low first", txOutData, 8'h03);
    idle(4);
    chk("R10 valid hold", txOutValid, 1);
    chk("R10 data hold", txOutData, 8'h03);
    dmaWr(8'h99); tcPulse();
    regRd(5'h0C, d); chk("R12 txst unchanged", d, 8'h6F);
    regWr(5'h0A, 8'h80); idle(10);
    regRd(5'h08, d); chk("R12 st0", d, 8'h01);
    regRd(5'h0F, d); chk("R12 b0", d, 8'h41);
    regRd(5'h0F, d); chk("R12 b1", d, 8'h42);
    regRd(5'h0F, d); chk("R12 b2", d, 8'h43);
    regRd(5'h08, d); chk("R12 no extra byte", d, 8'h06);
    // R9 ack high ignored
    dmaWr(8'h55); txAckN = 1'b1; tcPulse(); idle(4);
    regRd(5'h0C, d); chk("R9 ack high ignored", d, 8'h6B);
    chk("R9 nothing sent", txOutValid, 0);
    txAckN = 1'b0; tcPulse(); idle(8);
    regRd(5'h08, d); chk("R9 frame", d, 8'h41);
    regRd(5'h0F, d); chk("R9 data", d, 8'h55);
    // R11 transmit reset via control bit 3
    dmaWr(8'h61); dmaWr(8'h62);
    regWr(5'h0D, 8'h88);
    regRd(5'h0C, d); chk("R11 txst reset", d, 8'h6F);
    tcPulse(); idle(2);
    chk("R9 empty frame not sent", txOutValid, 0);
    idle(6);
    regRd(5'h08, d); chk("R11 nothing received", d, 8'h06);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule